// File: doc/BRIEF.md
# Line Error Event Counter Bank

This block keeps a set of 16-bit counters for line and PHY error events. Each counter adds one for every clock cycle on which its event input is high. A processor reads the counters through a simple strobe-and-select read port, and every read clears the value it returns. When a counter reaches its top value, its per-counter overflow interrupt enable decides what happens next. If the enable is set, the counter wraps to zero and records the overflow in a shared status register. If it is clear, the counter sticks at its top value until it is read.

A one-second strobe input can split counting into fixed intervals. When the global latching enable is set, each strobe copies every live count into a holding register and restarts the live count. Reads then return the held snapshot and clear it. The last counter in the bank counts line code violations, and it always works this way, whatever the global enable says. The overflow status register is read through the same port and clears on that read. An interrupt output is raised while any status bit is set whose overflow enable is also set.

The bank has `NUM_CNT` general counters at indices 0 to `NUM_CNT-1`. The code-violation counter sits at index `NUM_CNT`.

Top module: `line_evt_counters`

## Requirements
- R1: Each counter is `CNT_W` (16) bits wide and adds one on every clock edge at which its `evtPulse` bit is high. A read is made by holding `rdStrobe` high for one cycle with `rdStatus` low and the counter index on `rdSel`. The value appears on `rdData` after that clock edge.
- R2: If a counter's `ovflIntEn` bit is 1 and the counter holds 65535 when an event arrives, the counter becomes 0 and status bit i is set.
- R3: If a counter's `ovflIntEn` bit is 0, the counter stays at 65535 for further events until it is read or cleared. No status bit is set.
- R4: With `latchEnable` high, a cycle with `oneSecStrobe` high copies each live count into its holding register and clears the live count. A read then returns the holding register and clears it to 0.
- R5: The code-violation counter (index `NUM_CNT`) is always latched by `oneSecStrobe`, even with `latchEnable` low. With `latchEnable` low, the general counters ignore `oneSecStrobe`.
- R6: A read of the code-violation counter returns its held value and then clears it. Further reads before the next strobe return 0.
- R7: A read with `rdStatus` high returns the overflow status on `rdData`, with bit i belonging to counter i and the upper bits 0. The read clears the status, except for any overflow that occurs in that same cycle.
- R8: With latching off, a read returns the live count and clears it. An event in the same cycle as the read leaves the counter at 1.
- R9: An event in the same cycle as a latching strobe is counted into the new interval: the live count becomes 1, and the held value does not include that event.
- R10: `ovflIrq` is high exactly when some status bit i and `ovflIntEn[i]` are both 1. It follows changes of the enable in the same cycle.
- R11: After reset, all counters, holding registers, the status register and `rdData` are 0, and `ovflIrq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtPulse | input | NUM_CNT+1 | Event inputs, one per counter; the top bit is the code-violation counter |
| oneSecStrobe | input | 1 | One-cycle interval strobe |
| latchEnable | input | 1 | Global enable for interval latching of the general counters |
| ovflIntEn | input | NUM_CNT+1 | Per-counter overflow interrupt enable (wrap when 1, saturate when 0) |
| rdStrobe | input | 1 | Read request, one cycle |
| rdStatus | input | 1 | With rdStrobe, read the overflow status instead of a counter |
| rdSel | input | $clog2(NUM_CNT+1) | Counter index for a read |
| rdData | output | CNT_W | Read result, registered |
| ovflIrq | output | 1 | Overflow interrupt |

## Verification
The hardest state to reach from the ports is a counter at its top value. Getting there takes 65535 events, and only then can the wrap and saturate rules be seen. The stimulus drives one long run of 65537 events into two counters at once: one enabled to wrap and one left to saturate. A single pass then checks the final values of both counters, the status bit and the interrupt masking. The coincident cases are driven as single cycles that overlap an event with a read or with a strobe: an event together with a read, and an event together with a strobe.

// File: rtl/evc_pkg.sv
package evc_pkg;

  // Per-counter strobes issued by the control module
  typedef struct packed {
    logic snap;     // copy live to hold, restart live
    logic clrLive;  // live read: restart live
    logic clrHold;  // held read: clear hold
  } cellCmd_t;

  // Read-path strobes
  typedef struct packed {
    logic rdEn;
    logic rdStat;
    logic useHold;
  } rdCmd_t;

endpackage

// File: rtl/evc_ctrl.sv
module evc_ctrl
  import evc_pkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int SEL_W   = $clog2(NUM_CNT + 1)
) (
  input  logic             oneSecStrobe,
  input  logic             latchEnable,
  input  logic             rdStrobe,
  input  logic             rdStatus,
  input  logic [SEL_W-1:0] rdSel,
  output cellCmd_t         cellCmd [NUM_CNT+1],
  output rdCmd_t           rdCmd
);

  localparam int TOTAL  = NUM_CNT + 1;
  localparam int CV_IDX = NUM_CNT;

  for (genvar i = 0; i < TOTAL; i++) begin : g_cmd
    logic latchOn;
    logic picked;
    // the code-violation counter always runs in interval mode
    if (i == CV_IDX) begin : g_cv
      assign latchOn = 1'b1;
    end else begin : g_gen
      assign latchOn = latchEnable;
    end
    assign picked             = rdStrobe && !rdStatus && (rdSel == SEL_W'(i));
    assign cellCmd[i].snap    = oneSecStrobe && latchOn;
    assign cellCmd[i].clrLive = picked && !latchOn;
    assign cellCmd[i].clrHold = picked && latchOn;
  end

  always_comb begin
    rdCmd.rdEn    = rdStrobe;
    rdCmd.rdStat  = rdStatus;
    rdCmd.useHold = latchEnable || (rdSel == SEL_W'(CV_IDX));
  end

endmodule

// File: rtl/evc_cell.sv
module evc_cell
  import evc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             evt,
  input  logic             intEn,
  input  cellCmd_t         cmd,
  output logic [CNT_W-1:0] liveCnt,
  output logic [CNT_W-1:0] holdCnt,
  output logic             ovflPulse
);

  localparam logic [CNT_W-1:0] MAX_VAL = '1;
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic [CNT_W-1:0] nextLive;
  logic [CNT_W-1:0] nextHold;

  always_comb begin
    nextLive  = liveCnt;
    ovflPulse = 1'b0;
    if (cmd.snap || cmd.clrLive) begin
      // new interval: a coincident event is its first count
      nextLive = evt ? ONE : '0;
    end else if (evt) begin
      if (liveCnt == MAX_VAL) begin
        if (intEn) begin
          nextLive  = '0;
          ovflPulse = 1'b1;
        end
      end else begin
        nextLive = liveCnt + ONE;
      end
    end
  end

  always_comb begin
    nextHold = holdCnt;
    if (cmd.snap)         nextHold = liveCnt;
    else if (cmd.clrHold) nextHold = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      liveCnt <= '0;
      holdCnt <= '0;
    end else begin
      liveCnt <= nextLive;
      holdCnt <= nextHold;
    end
  end

  // R3: a saturated counter without interrupt enable stays put
  a_r3_saturate: assert property (@(posedge clk) disable iff (!rstN)
    (liveCnt == MAX_VAL && !intEn && !cmd.snap && !cmd.clrLive) |=> liveCnt == MAX_VAL);

  // R2: an enabled counter wraps to zero
  a_r2_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (liveCnt == MAX_VAL && intEn && evt && !cmd.snap && !cmd.clrLive) |=> liveCnt == '0);

  // R4: the strobe captures the live count
  a_r4_snap: assert property (@(posedge clk) disable iff (!rstN)
    cmd.snap |=> holdCnt == $past(liveCnt));

  // R9: a coincident event lands in the new interval
  a_r9_new_interval: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.snap && evt) |=> liveCnt == ONE);

  // R6: a held read clears the hold
  a_r6_hold_clear: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.clrHold && !cmd.snap) |=> holdCnt == '0);

endmodule

// File: rtl/evc_datapath.sv
module evc_datapath
  import evc_pkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 16,
  parameter int SEL_W   = $clog2(NUM_CNT + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_CNT:0]   evtPulse,
  input  logic [NUM_CNT:0]   ovflIntEn,
  input  cellCmd_t           cellCmd [NUM_CNT+1],
  input  rdCmd_t             rdCmd,
  input  logic [SEL_W-1:0]   rdSel,
  output logic [CNT_W-1:0]   rdData,
  output logic               ovflIrq
);

  localparam int TOTAL = NUM_CNT + 1;

  logic [CNT_W-1:0] liveArr [TOTAL];
  logic [CNT_W-1:0] holdArr [TOTAL];
  logic [TOTAL-1:0] ovflPulse;
  logic [TOTAL-1:0] statusReg;
  logic [CNT_W-1:0] rdMux;
  logic             statusRead;

  for (genvar i = 0; i < TOTAL; i++) begin : g_cell
    evc_cell #(.CNT_W(CNT_W)) u_cell (
      .clk       (clk),
      .rstN      (rstN),
      .evt       (evtPulse[i]),
      .intEn     (ovflIntEn[i]),
      .cmd       (cellCmd[i]),
      .liveCnt   (liveArr[i]),
      .holdCnt   (holdArr[i]),
      .ovflPulse (ovflPulse[i])
    );
  end

  assign statusRead = rdCmd.rdEn && rdCmd.rdStat;

  // set wins over the clear of a status read
  always_ff @(posedge clk) begin
    if (!rstN) statusReg <= '0;
    else       statusReg <= (statusRead ? '0 : statusReg) | ovflPulse;
  end

  assign ovflIrq = |(statusReg & ovflIntEn);

  always_comb begin
    rdMux = '0;
    if (rdCmd.rdStat) begin
      rdMux = CNT_W'(statusReg);
    end else begin
      for (int i = 0; i < TOTAL; i++) begin
        if (rdSel == SEL_W'(i)) rdMux = rdCmd.useHold ? holdArr[i] : liveArr[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          rdData <= '0;
    else if (rdCmd.rdEn) rdData <= rdMux;
  end

  // R7: status read with no new overflow leaves the register empty
  a_r7_status_clear: assert property (@(posedge clk) disable iff (!rstN)
    (statusRead && ovflPulse == '0) |=> statusReg == '0);

  // R7: status bits are sticky between status reads
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !statusRead |=> (statusReg & $past(statusReg)) == $past(statusReg));

  for (genvar i = 0; i < TOTAL; i++) begin : g_chk
    // R2: every wrap is recorded
    a_r2_status_set: assert property (@(posedge clk) disable iff (!rstN)
      ovflPulse[i] |=> statusReg[i]);
  end

  initial begin
    a_r7_fits: assert (TOTAL <= CNT_W);
  end

endmodule

// File: rtl/line_evt_counters.sv
module line_evt_counters
  import evc_pkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_CNT:0]             evtPulse,
  input  logic                         oneSecStrobe,
  input  logic                         latchEnable,
  input  logic [NUM_CNT:0]             ovflIntEn,
  input  logic                         rdStrobe,
  input  logic                         rdStatus,
  input  logic [$clog2(NUM_CNT+1)-1:0] rdSel,
  output logic [CNT_W-1:0]             rdData,
  output logic                         ovflIrq
);

  localparam int TOTAL = NUM_CNT + 1;
  localparam int SEL_W = $clog2(TOTAL);

  cellCmd_t cellCmd [TOTAL];
  rdCmd_t   rdCmd;

  evc_ctrl #(.NUM_CNT(NUM_CNT), .SEL_W(SEL_W)) u_ctrl (
    .oneSecStrobe (oneSecStrobe),
    .latchEnable  (latchEnable),
    .rdStrobe     (rdStrobe),
    .rdStatus     (rdStatus),
    .rdSel        (rdSel),
    .cellCmd      (cellCmd),
    .rdCmd        (rdCmd)
  );

  evc_datapath #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .SEL_W(SEL_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .evtPulse  (evtPulse),
    .ovflIntEn (ovflIntEn),
    .cellCmd   (cellCmd),
    .rdCmd     (rdCmd),
    .rdSel     (rdSel),
    .rdData    (rdData),
    .ovflIrq   (ovflIrq)
  );

endmodule

// File: tb/line_evt_counters_test.sv
`timescale 1ns/1ps
module line_evt_counters_test;

  localparam int NC = 4;
  localparam int CV = NC;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [NC:0] evtPulse = '0;
  logic        oneSecStrobe = 1'b0;
  logic        latchEnable = 1'b0;
  logic [NC:0] ovflIntEn = '0;
  logic        rdStrobe = 1'b0;
  logic        rdStatus = 1'b0;
  logic [2:0]  rdSel = '0;
  logic [15:0] rdData;
  logic        ovflIrq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  line_evt_counters #(.NUM_CNT(NC), .CNT_W(16)) uut (
    .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .oneSecStrobe(oneSecStrobe),
    .latchEnable(latchEnable), .ovflIntEn(ovflIntEn), .rdStrobe(rdStrobe),
    .rdStatus(rdStatus), .rdSel(rdSel), .rdData(rdData), .ovflIrq(ovflIrq)
  );

  // table: counter index, events driven, value expected on the read
  localparam int VEC_N = 5;
  localparam int VEC_IDX [VEC_N] = '{0, 1, 2, 3, 2};
  localparam int VEC_CNT [VEC_N] = '{3, 10, 1, 0, 0};
  localparam int VEC_EXP [VEC_N] = '{3, 10, 1, 0, 0};

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic pulse(input logic [NC:0] mask, input int n);
    if (n > 0) begin
      @(negedge clk) evtPulse = mask;
      repeat (n) @(negedge clk);
      evtPulse = '0;
    end
  endtask

  task automatic doRead(input logic stat, input int sel, input logic [NC:0] evtMask,
                        output int val);
    @(negedge clk);
    rdStrobe = 1'b1; rdStatus = stat; rdSel = 3'(sel); evtPulse = evtMask;
    @(negedge clk);
    rdStrobe = 1'b0; rdStatus = 1'b0; evtPulse = '0;
    val = int'(rdData);
  endtask

  task automatic strobe(input logic [NC:0] evtMask);
    @(negedge clk);
    oneSecStrobe = 1'b1; evtPulse = evtMask;
    @(negedge clk);
    oneSecStrobe = 1'b0; evtPulse = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R11 rdData after reset", int'(rdData), 0);
    check("R11 ovflIrq after reset", int'(ovflIrq), 0);
    doRead(1'b1, 0, '0, v); check("R11 status after reset", v, 0);
    doRead(1'b0, CV, '0, v); check("R11 cv hold after reset", v, 0);

    // R1: table of counts with latching off
    for (int k = 0; k < VEC_N; k++) begin
      pulse(5'(1) << VEC_IDX[k], VEC_CNT[k]);
      doRead(1'b0, VEC_IDX[k], '0, v);
      check($sformatf("R1 vector %0d", k), v, VEC_EXP[k]);
    end

    // R8: read clears live; coincident event starts at 1
    pulse(5'b00100, 4);
    doRead(1'b0, 2, 5'b00100, v); check("R8 live read value", v, 4);
    doRead(1'b0, 2, '0, v);       check("R8 coincident event counted", v, 1);

    // R5: general counter ignores strobe with latching off
    pulse(5'b01000, 4);
    strobe('0);
    doRead(1'b0, 3, '0, v); check("R5 general ignores strobe", v, 4);

    // R5, R6: code-violation counter always latched
    pulse(5'b10000, 7);
    doRead(1'b0, CV, '0, v); check("R5 cv read before strobe", v, 0);
    strobe('0);
    doRead(1'b0, CV, '0, v); check("R6 cv held value", v, 7);
    doRead(1'b0, CV, '0, v); check("R6 cv second read zero", v, 0);

    // R4, R9: global latching
    latchEnable = 1'b1;
    pulse(5'b00001, 5);
    strobe('0);
    doRead(1'b0, 0, '0, v); check("R4 latched value", v, 5);
    doRead(1'b0, 0, '0, v); check("R4 hold cleared by read", v, 0);
    pulse(5'b00001, 2);
    strobe(5'b00001);
    doRead(1'b0, 0, '0, v); check("R9 held excludes coincident event", v, 2);
    strobe('0);
    doRead(1'b0, 0, '0, v); check("R9 coincident event in new interval", v, 1);
    latchEnable = 1'b0;

    // R2, R3, R7, R10: long run, counter 1 wraps, counter 0 saturates
    ovflIntEn = 5'b00010;
    pulse(5'b00011, 65537);
    #1 check("R10 irq with enabled status", int'(ovflIrq), 1);
    ovflIntEn = 5'b00000;
    #1 check("R10 irq masked by enable", int'(ovflIrq), 0);
    ovflIntEn = 5'b00010;
    #1 check("R10 irq follows enable", int'(ovflIrq), 1);
    doRead(1'b1, 0, '0, v); check("R7 status bit 1 only", v, 2);
    #1 check("R7 irq after status read", int'(ovflIrq), 0);
    doRead(1'b1, 0, '0, v); check("R7 status cleared", v, 0);
    doRead(1'b0, 0, '0, v); check("R3 saturated at max", v, 65535);
    doRead(1'b0, 1, '0, v); check("R2 wrapped count", v, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule